// File: doc/BRIEF.md
# Hypervisor Coprocessor Access Trap Unit

This block sits beside the system-register file of a processor core that runs a virtualising hypervisor. It owns one 32-bit trap-control register. Every system-register move that the decoder presents is classified by this block as completing, undefined, or trapping to the hypervisor level. Bits 0 to 15 of the register each arm a trap for one index value. The index is taken from CRn for a single-register move and from CRm for a dual-register move. Only non-secure accesses at levels 0 and 1 to coprocessor 15 can be caught this way.

The block also decides accesses to the trap-control register itself. It lives at coprocessor 15, opc1 4, CRn 1, CRm 1, opc2 3. The decision follows the requester's level first and then the secure flag. Because the rest of the register file is outside the block, the requester supplies `req_lower_undef`. This flag says whether the access would be undefined if no trap applied. It lets a level-0 access trap only when it would otherwise have been legal.

Each request is a one-cycle `req_valid` pulse, and requests may arrive back to back. A two-state machine drives `rsp_valid`. **ST_IDLE** goes to **ST_RESP** on `req_valid`. **ST_RESP** stays in **ST_RESP** on another `req_valid`. **ST_RESP** returns to **ST_IDLE** when no request arrives. The response registers are loaded on the same edge, so every result appears exactly one cycle after its request.

Top module: `cp_trap_unit`

## Requirements
- R1: After reset, `rsp_valid` is low and the trap-control register holds zero, so a level-2 read of it returns 0.
- R2: Only bits 15:0 other than 14 and 4 of the trap-control register are storable. A write leaves all other bits zero, and a set bit 14 or bit 4 arms no trap.
- R3: When register bit n is set, a non-secure level-1 single-register access to coprocessor 15 with CRn = n returns `rsp_trap` = 1 with `rsp_syndrome` = 0x03. CRm plays no part in this match. `rsp_syndrome` is 0 whenever `rsp_trap` is 0.
- R4: When register bit n is set, a non-secure level-1 dual-register access to coprocessor 15 with CRm = n traps with `rsp_syndrome` = 0x04. CRn plays no part in this match.
- R5: A non-secure level-0 access that matches a set bit traps only when `req_lower_undef` is 0. With `req_lower_undef` = 1 it reports `rsp_undef` = 1 and no trap.
- R6: Any level-0 access to the trap-control register address is undefined.
- R7: A level-1 access to the trap-control register traps with syndrome 0x03 when `hyp_en` = 1, the access is non-secure and register bit 1 is set. Otherwise it is undefined and a write has no effect.
- R8: At level 2 the trap-control register is read and written normally, whatever the secure flag. At level 3 it is read and written normally when non-secure. At level 3 with the secure flag set it is undefined and a write has no effect.
- R9: Secure accesses, and accesses to any coprocessor other than 15, are never trapped by this block. For such accesses to other registers, `rsp_undef` equals `req_lower_undef`.
- R10: With `hyp_en` = 0, no response has `rsp_trap` set.
- R11: Each request is answered by `rsp_valid` exactly one cycle later. Back-to-back requests give back-to-back responses, and a cycle without a request gives a cycle without a response.
- R12: `rsp_rdata` is zero except on a completed read of the trap-control register. Trap and undefined responses never have both flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hyp_en | input | 1 | Hypervisor level is enabled |
| req_valid | input | 1 | A request is presented this cycle |
| req_level | input | 2 | Privilege level of the requester (0 to 3) |
| req_secure | input | 1 | Requester is in secure state |
| req_dual | input | 1 | 1 = dual-register move, 0 = single-register move |
| req_write | input | 1 | 1 = write to the register, 0 = read |
| req_coproc | input | 4 | Coprocessor number |
| req_opc1 | input | 3 | opc1 field |
| req_crn | input | 4 | CRn field |
| req_crm | input | 4 | CRm field |
| req_opc2 | input | 3 | opc2 field |
| req_wdata | input | 32 | Write data |
| req_lower_undef | input | 1 | The access would be undefined without any trap |
| rsp_valid | output | 1 | Response is valid this cycle |
| rsp_rdata | output | 32 | Read data of the trap-control register |
| rsp_trap | output | 1 | Access traps to the hypervisor level |
| rsp_syndrome | output | 6 | Syndrome code of the trap |
| rsp_undef | output | 1 | Access is undefined |

## Verification
The hardest case to reach from the ports is a level-1 trap on the trap-control register itself. It needs bit 1 to be set first, and that is only possible through a level-2 or non-secure level-3 write. The bench then checks that a blocked write at level 1 or at secure level 3 left the contents unchanged, which it can only see by reading the register back at level 2. The level-0 rule is reached by repeating one matching access with `req_lower_undef` low and then high. A sweep loads each single index bit in turn, including the two reserved positions, and probes that index and its neighbour with single and dual moves. Most requests run back to back, so the one-cycle response rule is exercised under a continuous stream.

// File: rtl/cptu_pkg.sv
`timescale 1ns/1ps
package cptu_pkg;

    localparam int FLD_W = 4;   // CRn / CRm / coprocessor field width
    localparam int OPC_W = 3;   // opc1 / opc2 field width
    localparam int LVL_W = 2;   // privilege level width

    localparam logic [FLD_W-1:0] CP_SYS    = 4'hF;
    localparam logic [OPC_W-1:0] SELF_OPC1 = 3'd4;
    localparam logic [FLD_W-1:0] SELF_CRN  = 4'd1;
    localparam logic [FLD_W-1:0] SELF_CRM  = 4'd1;
    localparam logic [OPC_W-1:0] SELF_OPC2 = 3'd3;
    localparam int               SELF_GATE = 1;  // control bit gating level-1 self access

    typedef enum logic [LVL_W-1:0] {
        LVL_USER = 2'd0,
        LVL_KERN = 2'd1,
        LVL_HYP  = 2'd2,
        LVL_MON  = 2'd3
    } level_e;

    typedef enum logic [1:0] {
        OUT_DONE  = 2'd0,
        OUT_UNDEF = 2'd1,
        OUT_TRAP  = 2'd2
    } outcome_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;

endpackage

// File: rtl/cptu_ctrl_reg.sv
`timescale 1ns/1ps
module cptu_ctrl_reg #(
    parameter int                REG_W  = 32,
    parameter int                NUM_T  = 16,
    parameter logic [NUM_T-1:0]  RSVD_T = 16'h4010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] value
);
    localparam logic [REG_W-1:0] LIVE = {{(REG_W-NUM_T){1'b0}}, ~RSVD_T};

    logic [REG_W-1:0] value_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (wr_en) begin
            value_q <= wr_data & LIVE;
        end
    end

    assign value = value_q;
endmodule

// File: rtl/cptu_self_access.sv
`timescale 1ns/1ps
module cptu_self_access
    import cptu_pkg::*;
(
    input  logic             dual,
    input  logic [FLD_W-1:0] coproc,
    input  logic [OPC_W-1:0] opc1,
    input  logic [FLD_W-1:0] crn,
    input  logic [FLD_W-1:0] crm,
    input  logic [OPC_W-1:0] opc2,
    input  logic [LVL_W-1:0] level,
    input  logic             secure,
    input  logic             hyp_en,
    input  logic             gate_bit,
    output logic             hit,
    output outcome_e         outcome
);
    assign hit = !dual && (coproc == CP_SYS) && (opc1 == SELF_OPC1) &&
                 (crn == SELF_CRN) && (crm == SELF_CRM) && (opc2 == SELF_OPC2);

    // Priority: requester level first, then the secure state.
    always_comb begin
        unique case (level_e'(level))
            LVL_USER: outcome = OUT_UNDEF;
            LVL_KERN: outcome = (hyp_en && !secure && gate_bit) ? OUT_TRAP : OUT_UNDEF;
            LVL_HYP:  outcome = OUT_DONE;
            LVL_MON:  outcome = secure ? OUT_UNDEF : OUT_DONE;
            default:  outcome = OUT_UNDEF;
        endcase
    end
endmodule

// File: rtl/cptu_index_trap.sv
`timescale 1ns/1ps
module cptu_index_trap
    import cptu_pkg::*;
#(
    parameter int NUM_T = 16
) (
    input  logic [NUM_T-1:0] ctl,
    input  logic             dual,
    input  logic [FLD_W-1:0] coproc,
    input  logic [FLD_W-1:0] crn,
    input  logic [FLD_W-1:0] crm,
    input  logic [LVL_W-1:0] level,
    input  logic             secure,
    input  logic             hyp_en,
    input  logic             lower_undef,
    output logic             trap
);
    logic [FLD_W-1:0] idx;
    logic [NUM_T-1:0] hit;
    logic             armed;
    logic             lvl_ok;

    // Single moves are indexed by CRn, dual moves by CRm.
    assign idx = dual ? crm : crn;

    for (genvar i = 0; i < NUM_T; i++) begin : g_hit
        assign hit[i] = ctl[i] && (idx == FLD_W'(i));
    end

    assign armed = hyp_en && !secure && (coproc == CP_SYS) && (|hit);

    always_comb begin
        unique case (level_e'(level))
            LVL_KERN: lvl_ok = 1'b1;
            LVL_USER: lvl_ok = !lower_undef;
            default:  lvl_ok = 1'b0;
        endcase
    end

    assign trap = armed && lvl_ok;
endmodule

// File: rtl/cp_trap_unit.sv
`timescale 1ns/1ps
module cp_trap_unit
    import cptu_pkg::*;
#(
    parameter int               REG_W      = 32,
    parameter int               NUM_T      = 16,
    parameter logic [NUM_T-1:0] RSVD_T     = 16'h4010,
    parameter int               SYN_W      = 6,
    parameter logic [SYN_W-1:0] SYN_SINGLE = 6'h03,
    parameter logic [SYN_W-1:0] SYN_DUAL   = 6'h04
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hyp_en,
    input  logic             req_valid,
    input  logic [1:0]       req_level,
    input  logic             req_secure,
    input  logic             req_dual,
    input  logic             req_write,
    input  logic [3:0]       req_coproc,
    input  logic [2:0]       req_opc1,
    input  logic [3:0]       req_crn,
    input  logic [3:0]       req_crm,
    input  logic [2:0]       req_opc2,
    input  logic [REG_W-1:0] req_wdata,
    input  logic             req_lower_undef,
    output logic             rsp_valid,
    output logic [REG_W-1:0] rsp_rdata,
    output logic             rsp_trap,
    output logic [SYN_W-1:0] rsp_syndrome,
    output logic             rsp_undef
);
    state_e           state_q, state_d;
    logic [REG_W-1:0] ctl_value;
    logic             self_hit;
    outcome_e         self_out;
    logic             idx_trap;
    outcome_e         outcome;
    logic [SYN_W-1:0] syn_d;
    logic             self_grant;
    logic             ctl_wr;
    logic [REG_W-1:0] rdata_d;

    cptu_ctrl_reg #(
        .REG_W  (REG_W),
        .NUM_T  (NUM_T),
        .RSVD_T (RSVD_T)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr),
        .wr_data (req_wdata),
        .value   (ctl_value)
    );

    cptu_self_access u_self (
        .dual     (req_dual),
        .coproc   (req_coproc),
        .opc1     (req_opc1),
        .crn      (req_crn),
        .crm      (req_crm),
        .opc2     (req_opc2),
        .level    (req_level),
        .secure   (req_secure),
        .hyp_en   (hyp_en),
        .gate_bit (ctl_value[SELF_GATE]),
        .hit      (self_hit),
        .outcome  (self_out)
    );

    cptu_index_trap #(
        .NUM_T (NUM_T)
    ) u_idx (
        .ctl         (ctl_value[NUM_T-1:0]),
        .dual        (req_dual),
        .coproc      (req_coproc),
        .crn         (req_crn),
        .crm         (req_crm),
        .level       (req_level),
        .secure      (req_secure),
        .hyp_en      (hyp_en),
        .lower_undef (req_lower_undef),
        .trap        (idx_trap)
    );

    // Decision: own register first, then index trap, then pass-through.
    always_comb begin
        outcome = OUT_DONE;
        syn_d   = '0;
        if (self_hit) begin
            outcome = self_out;
            if (self_out == OUT_TRAP) begin
                syn_d = SYN_SINGLE;
            end
        end else if (idx_trap) begin
            outcome = OUT_TRAP;
            syn_d   = req_dual ? SYN_DUAL : SYN_SINGLE;
        end else if (req_lower_undef) begin
            outcome = OUT_UNDEF;
        end
    end

    assign self_grant = self_hit && (self_out == OUT_DONE);
    assign ctl_wr     = req_valid && self_grant && req_write;
    assign rdata_d    = (self_grant && !req_write) ? ctl_value : '0;

    // Next-state logic.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata    <= '0;
            rsp_trap     <= 1'b0;
            rsp_syndrome <= '0;
            rsp_undef    <= 1'b0;
        end else if (req_valid) begin
            rsp_rdata    <= rdata_d;
            rsp_trap     <= (outcome == OUT_TRAP);
            rsp_syndrome <= syn_d;
            rsp_undef    <= (outcome == OUT_UNDEF);
        end else begin
            rsp_rdata    <= '0;
            rsp_trap     <= 1'b0;
            rsp_syndrome <= '0;
            rsp_undef    <= 1'b0;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);
endmodule

// File: rtl/cptu_checker.sv
`timescale 1ns/1ps
module cptu_checker
    import cptu_pkg::*;
#(
    parameter int               REG_W    = 32,
    parameter int               NUM_T    = 16,
    parameter logic [NUM_T-1:0] RSVD_T   = 16'h4010,
    parameter int               SYN_W    = 6,
    parameter logic [SYN_W-1:0] SYN_DUAL = 6'h04
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hyp_en,
    input logic             req_valid,
    input logic [1:0]       req_level,
    input logic             req_secure,
    input logic             req_dual,
    input logic             req_write,
    input logic [3:0]       req_coproc,
    input logic [2:0]       req_opc1,
    input logic [3:0]       req_crn,
    input logic [3:0]       req_crm,
    input logic [2:0]       req_opc2,
    input logic             rsp_valid,
    input logic [REG_W-1:0] rsp_rdata,
    input logic             rsp_trap,
    input logic [SYN_W-1:0] rsp_syndrome,
    input logic             rsp_undef
);
    localparam logic [REG_W-1:0] LIVE = {{(REG_W-NUM_T){1'b0}}, ~RSVD_T};

    logic self_addr;
    assign self_addr = !req_dual && (req_coproc == CP_SYS) && (req_opc1 == SELF_OPC1) &&
                       (req_crn == SELF_CRN) && (req_crm == SELF_CRM) && (req_opc2 == SELF_OPC2);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_rdata & ~LIVE) == '0);

    p_dual_syndrome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_dual && !self_addr |=> !rsp_trap || (rsp_syndrome == SYN_DUAL));

    p_user_self_undef_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && self_addr && (req_level == 2'd0) |=> rsp_undef && !rsp_trap);

    p_upper_never_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_level[1] |=> !rsp_trap);

    p_secure_never_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_secure |=> !rsp_trap);

    p_disabled_never_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !hyp_en |=> !rsp_trap);

    p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_rsp_without_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_flags_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_trap && rsp_undef));

    p_write_no_rdata_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |=> rsp_rdata == '0);

    p_no_syndrome_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_trap |-> rsp_syndrome == '0);
endmodule

bind cp_trap_unit cptu_checker #(
    .REG_W    (REG_W),
    .NUM_T    (NUM_T),
    .RSVD_T   (RSVD_T),
    .SYN_W    (SYN_W),
    .SYN_DUAL (SYN_DUAL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hyp_en       (hyp_en),
    .req_valid    (req_valid),
    .req_level    (req_level),
    .req_secure   (req_secure),
    .req_dual     (req_dual),
    .req_write    (req_write),
    .req_coproc   (req_coproc),
    .req_opc1     (req_opc1),
    .req_crn      (req_crn),
    .req_crm      (req_crm),
    .req_opc2     (req_opc2),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .rsp_trap     (rsp_trap),
    .rsp_syndrome (rsp_syndrome),
    .rsp_undef    (rsp_undef)
);

// File: tb/cp_trap_unit_test.sv
`timescale 1ns/1ps
module cp_trap_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hyp_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_level = '0;
    logic        req_secure = 1'b0;
    logic        req_dual = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_coproc = '0;
    logic [2:0]  req_opc1 = '0;
    logic [3:0]  req_crn = '0;
    logic [3:0]  req_crm = '0;
    logic [2:0]  req_opc2 = '0;
    logic [31:0] req_wdata = '0;
    logic        req_lower_undef = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_trap;
    logic [5:0]  rsp_syndrome;
    logic        rsp_undef;

    always #4 clk = ~clk;  // 125 MHz

    cp_trap_unit uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .hyp_en          (hyp_en),
        .req_valid       (req_valid),
        .req_level       (req_level),
        .req_secure      (req_secure),
        .req_dual        (req_dual),
        .req_write       (req_write),
        .req_coproc      (req_coproc),
        .req_opc1        (req_opc1),
        .req_crn         (req_crn),
        .req_crm         (req_crm),
        .req_opc2        (req_opc2),
        .req_wdata       (req_wdata),
        .req_lower_undef (req_lower_undef),
        .rsp_valid       (rsp_valid),
        .rsp_rdata       (rsp_rdata),
        .rsp_trap        (rsp_trap),
        .rsp_syndrome    (rsp_syndrome),
        .rsp_undef       (rsp_undef)
    );

    typedef struct {
        logic        trap;
        logic [5:0]  syn;
        logic        undef;
        logic [31:0] rdata;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] model = '0;
    bit          finished = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Driver: presents one request and pushes the predicted response.
    task automatic send(input logic [1:0] lvl, input logic sec, input logic dual,
                        input logic wr, input logic [3:0] cp, input logic [2:0] o1,
                        input logic [3:0] crn, input logic [3:0] crm, input logic [2:0] o2,
                        input logic [31:0] wd, input logic lu, input logic hen,
                        input string tag);
        exp_t e;
        bit   self_a;
        bit   ok;
        int   n;
        @(negedge clk);
        req_valid = 1'b1; req_level = lvl; req_secure = sec; req_dual = dual;
        req_write = wr; req_coproc = cp; req_opc1 = o1; req_crn = crn; req_crm = crm;
        req_opc2 = o2; req_wdata = wd; req_lower_undef = lu; hyp_en = hen;
        e.trap = 0; e.syn = 0; e.undef = 0; e.rdata = 0; e.tag = tag;
        self_a = !dual && cp == 4'd15 && o1 == 3'd4 && crn == 4'd1 && crm == 4'd1 && o2 == 3'd3;
        if (self_a) begin
            ok = 0;
            case (lvl)
                2'd0: e.undef = 1;
                2'd1: if (hen && !sec && model[1]) begin e.trap = 1; e.syn = 6'h03; end
                      else e.undef = 1;
                2'd2: ok = 1;
                default: if (sec) e.undef = 1; else ok = 1;
            endcase
            if (ok) begin
                if (wr) model = wd & 32'h0000_BFEF;
                else    e.rdata = model;
            end
        end else begin
            n = dual ? int'(crm) : int'(crn);
            if (hen && !sec && cp == 4'd15 && model[n] && (lvl == 2'd1 || (lvl == 2'd0 && !lu))) begin
                e.trap = 1;
                e.syn  = dual ? 6'h04 : 6'h03;
            end else begin
                e.undef = lu;
            end
        end
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ctl_wr(input logic [31:0] v, input string tag);
        send(2'd2, 0, 0, 1, 4'd15, 3'd4, 4'd1, 4'd1, 3'd3, v, 0, 1, tag);
    endtask

    task automatic ctl_rd(input string tag);
        send(2'd2, 0, 0, 0, 4'd15, 3'd4, 4'd1, 4'd1, 3'd3, 32'h0, 0, 1, tag);
    endtask

    // Monitor: pops and compares each response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check(0, "R11", "unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_trap == e.trap && rsp_syndrome == e.syn && rsp_undef == e.undef &&
                      rsp_rdata == e.rdata, e.tag, "trap/syn/undef/rdata",
                      {rsp_rdata[23:0], rsp_trap, rsp_undef, rsp_syndrome},
                      {e.rdata[23:0], e.trap, e.undef, e.syn});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        ctl_rd("R1 reset value");

        // R2 / R8: write all ones at level 2, read masked value back
        ctl_wr(32'hFFFF_FFFF, "R8 level-2 write");
        ctl_rd("R2 reserved bits read zero");

        // R3 / R4: bit 7 armed
        ctl_wr(32'h0000_0080, "R8 level-2 write");
        send(2'd1, 0, 0, 0, 4'd15, 3'd0, 4'd7, 4'd3, 3'd0, 0, 0, 1, "R3 single CRn=7 read");
        send(2'd1, 0, 0, 1, 4'd15, 3'd0, 4'd7, 4'd0, 3'd0, 0, 0, 1, "R3 single CRn=7 write");
        send(2'd1, 0, 0, 0, 4'd15, 3'd0, 4'd6, 4'd7, 3'd0, 0, 0, 1, "R3 single CRn=6 no trap");
        send(2'd1, 0, 1, 0, 4'd15, 3'd0, 4'd0, 4'd7, 3'd0, 0, 0, 1, "R4 dual CRm=7");
        send(2'd1, 0, 1, 1, 4'd15, 3'd0, 4'd7, 4'd0, 3'd0, 0, 0, 1, "R4 dual CRn=7 no trap");
        // R5: level 0
        send(2'd0, 0, 0, 0, 4'd15, 3'd0, 4'd7, 4'd0, 3'd0, 0, 0, 1, "R5 level0 legal traps");
        send(2'd0, 0, 0, 0, 4'd15, 3'd0, 4'd7, 4'd0, 3'd0, 0, 1, 1, "R5 level0 undef stays");
        send(2'd0, 0, 1, 0, 4'd15, 3'd0, 4'd0, 4'd7, 3'd0, 0, 0, 1, "R5 level0 dual traps");
        // R9: secure and other coprocessor
        send(2'd1, 1, 0, 0, 4'd15, 3'd0, 4'd7, 4'd0, 3'd0, 0, 0, 1, "R9 secure no trap");
        send(2'd1, 1, 0, 0, 4'd15, 3'd0, 4'd7, 4'd0, 3'd0, 0, 1, 1, "R9 secure undef passes");
        send(2'd1, 0, 0, 0, 4'd14, 3'd0, 4'd7, 4'd0, 3'd0, 0, 0, 1, "R9 other coproc");
        send(2'd0, 0, 1, 0, 4'd14, 3'd0, 4'd0, 4'd7, 3'd0, 0, 1, 1, "R9 other coproc undef");
        // R10
        send(2'd1, 0, 0, 0, 4'd15, 3'd0, 4'd7, 4'd0, 3'd0, 0, 0, 0, "R10 disabled single");
        send(2'd1, 0, 1, 0, 4'd15, 3'd0, 4'd0, 4'd7, 3'd0, 0, 0, 0, "R10 disabled dual");
        idle();
        idle();

        // R6 / R7: self access
        send(2'd0, 0, 0, 0, 4'd15, 3'd4, 4'd1, 4'd1, 3'd3, 0, 0, 1, "R6 level0 self read");
        send(2'd0, 0, 0, 1, 4'd15, 3'd4, 4'd1, 4'd1, 3'd3, 32'hFFFF, 0, 1, "R6 level0 self write");
        send(2'd1, 0, 0, 0, 4'd15, 3'd4, 4'd1, 4'd1, 3'd3, 0, 0, 1, "R7 bit1 clear undef");
        ctl_wr(32'h0000_0082, "R8 level-2 write");
        send(2'd1, 0, 0, 0, 4'd15, 3'd4, 4'd1, 4'd1, 3'd3, 0, 0, 1, "R7 bit1 set traps");
        send(2'd1, 0, 0, 1, 4'd15, 3'd4, 4'd1, 4'd1, 3'd3, 32'h1, 0, 0, "R7 disabled write undef");
        send(2'd1, 1, 0, 1, 4'd15, 3'd4, 4'd1, 4'd1, 3'd3, 32'h1, 0, 1, "R7 secure write undef");
        ctl_rd("R7 blocked writes left value");
        // R8: level 3
        send(2'd3, 1, 0, 1, 4'd15, 3'd4, 4'd1, 4'd1, 3'd3, 32'hFFFF, 0, 1, "R8 secure L3 write undef");
        send(2'd3, 1, 0, 0, 4'd15, 3'd4, 4'd1, 4'd1, 3'd3, 0, 0, 1, "R8 secure L3 read undef");
        ctl_rd("R8 value unchanged");
        send(2'd3, 0, 0, 1, 4'd15, 3'd4, 4'd1, 4'd1, 3'd3, 32'h0010_0003, 0, 1, "R8 ns L3 write");
        send(2'd3, 0, 0, 0, 4'd15, 3'd4, 4'd1, 4'd1, 3'd3, 0, 0, 1, "R8 ns L3 read");
        send(2'd2, 1, 0, 0, 4'd15, 3'd4, 4'd1, 4'd1, 3'd3, 0, 0, 1, "R8 secure L2 read");
        send(2'd2, 0, 0, 0, 4'd15, 3'd0, 4'd1, 4'd0, 3'd0, 0, 0, 1, "R8 L2 other reg no trap");
        // R2: reserved bits 4 and 14 arm nothing
        ctl_wr(32'h0000_4010, "R2 write reserved");
        send(2'd1, 0, 0, 0, 4'd15, 3'd0, 4'd14, 4'd0, 3'd0, 0, 0, 1, "R2 bit14 no trap");
        send(2'd1, 0, 1, 0, 4'd15, 3'd0, 4'd0, 4'd4, 3'd0, 0, 0, 1, "R2 bit4 no trap");
        idle();

        // Sweep of each index: R3 R4
        for (int n = 0; n < 16; n++) begin
            ctl_wr(32'(1) << n, "R8 sweep write");
            send(2'd1, 0, 0, 0, 4'd15, 3'd0, 4'(n), 4'd0, 3'd0, 0, 0, 1, "R3 sweep hit");
            send(2'd1, 0, 0, 0, 4'd15, 3'd0, 4'(n + 1), 4'd0, 3'd0, 0, 0, 1, "R3 sweep neighbour");
            send(2'd1, 0, 1, 0, 4'd15, 3'd0, 4'd0, 4'(n), 3'd0, 0, 0, 1, "R4 sweep hit");
        end
        idle();
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R11", "responses missing", 32'(sb.size()), 32'd0);
        check(rsp_valid == 1'b0, "R11", "idle response", 32'(rsp_valid), 32'd0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule